// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

This block compares two divided pulse trains that arrive at the same clock: a reference stream (`ref_div`) and a feedback stream (`fb_div`). Whichever stream rises first drives its correction output low. That output stays low until the other stream rises. Both corrections then stay low together for a fixed number of clocks, and after that both return high. The low time of each output tells the charge pump, or a digital loop filter, how far apart the two edges were and in which direction.

The block also exports a combined activity signal. This is the NAND of the two active-low corrections, so it is high whenever either correction is active. A lock flag watches the width of each activity burst. It rises after a run of comparisons in which every burst was narrow. It falls as soon as one burst grows too long. A clock-domain counter replaces the external RC filter that would otherwise smooth the activity signal.

All inputs are sampled on `clk`. A rising edge is seen when an input is high at a clock edge and was low at the previous clock edge.

Top module: `pfd_lockdet`

## Requirements
- R1: While `rst` is high, and at the first sample after it is released, `corr_up_n`=1, `corr_dn_n`=1, `pulse_nand`=0 and `lock_det`=0.
- R2: A rising edge on `ref_div` with no pending feedback edge drives `corr_up_n` low from the next clock. If the feedback edge follows k clocks later, `corr_up_n` stays low for k+RST_HOLD clocks.
- R3: A rising edge on `fb_div` with no pending reference edge drives `corr_dn_n` low from the next clock. If the reference edge follows k clocks later, `corr_dn_n` stays low for k+RST_HOLD clocks.
- R4: Once both corrections are low, they stay low together for exactly RST_HOLD clocks and then return high on the same clock.
- R5: When both inputs rise on the same clock, both corrections pulse low for exactly RST_HOLD clocks.
- R6: On every clock, `pulse_nand` equals the NAND of `corr_up_n` and `corr_dn_n`.
- R7: A rising edge has no effect if it arrives on an input whose correction is already low, or while both corrections are held low. It neither lengthens the pulse nor starts a new one.
- R8: `lock_det` rises on the clock after a burst of `pulse_nand` ends, provided that burst completes LOCK_COUNT consecutive bursts that were each high for at most LOCK_WIN clocks. A burst of exactly LOCK_WIN clocks counts as good.
- R9: `lock_det` falls on the clock after the (LOCK_WIN+1)-th consecutive high clock of `pulse_nand`, and the count of good bursts restarts from zero.
- R10: An input held high for many clocks counts as a single rising edge. It gives one correction pulse per low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_div | input | 1 | Divided reference pulse stream |
| fb_div | input | 1 | Divided feedback pulse stream |
| corr_up_n | output | 1 | Active-low correction: reference leads |
| corr_dn_n | output | 1 | Active-low correction: feedback leads |
| pulse_nand | output | 1 | NAND of the two corrections (activity) |
| lock_det | output | 1 | Filtered lock flag, high when locked |

## Verification
The embedded properties assume that both inputs are clean single-bit levels that change only between sampling edges. They also assume that a new comparison does not start until the previous hold window has finished. The only exception is the deliberate edge injected into the hold window to exercise R7. The stimulus drives inputs on the falling clock edge and holds each level for several clocks. After every comparison it returns both inputs low for a few idle clocks, so each burst is measured cleanly. Lead and lag offsets are chosen to fall on both sides of the LOCK_WIN threshold, including a burst exactly at the limit.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Channel indices into the sampled input vector
  localparam int CH_REF = 0;
  localparam int CH_FB  = 1;
  localparam int NUM_CH = 2;

  // Bits needed to hold values 0..n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  // Low-to-high transition between two successive samples
  assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int RST_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_ref_i,
  input  logic rise_fb_i,
  output logic up_o,
  output logic dn_o,
  output logic done_o
);

  localparam int HW = pfd_pkg::cnt_bits(RST_HOLD);
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);

  logic          up_q, dn_q;
  logic [HW-1:0] hold_q;
  logic          both;

  assign both   = up_q & dn_q;
  assign done_o = both & (hold_q == HOLD_LAST);
  assign up_o   = up_q;
  assign dn_o   = dn_q;

  // Tri-state detector: edges set their flag; once both are set, the
  // flags are held for RST_HOLD clocks and then cleared together.
  always_ff @(posedge clk) begin
    if (rst) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      hold_q <= '0;
    end else if (both) begin
      if (hold_q == HOLD_LAST) begin
        up_q   <= 1'b0;
        dn_q   <= 1'b0;
        hold_q <= '0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end else begin
      up_q <= up_q | rise_ref_i;
      dn_q <= dn_q | rise_fb_i;
    end
  end

  AST_UP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(up_q) |-> $past(rise_ref_i)); // R2
  AST_DN_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_q) |-> $past(rise_fb_i)); // R3
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(up_q) |-> $fell(dn_q)); // R4

  generate
    if (RST_HOLD > 1) begin : g_hold_chk
      AST_HOLD_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (up_q && dn_q && hold_q == '0) |=> (up_q && dn_q)); // R4
    end
  endgenerate

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int LOCK_WIN   = 4,
  parameter int LOCK_COUNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cext_i,
  input  logic done_i,
  output logic ld_o
);

  localparam int RW = pfd_pkg::cnt_bits(LOCK_WIN);
  localparam int GW = pfd_pkg::cnt_bits(LOCK_COUNT);
  localparam logic [RW-1:0] WIN_V  = RW'(LOCK_WIN);
  localparam logic [GW-1:0] CNT_V  = GW'(LOCK_COUNT);
  localparam logic [GW-1:0] CNT_M1 = GW'(LOCK_COUNT - 1);

  logic [RW-1:0] run_q;
  logic [GW-1:0] good_q;
  logic          ld_q;
  logic          too_long;

  // Current high clock is beyond the allowed burst width
  assign too_long = cext_i && (run_q >= WIN_V);
  assign ld_o     = ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      good_q <= '0;
      ld_q   <= 1'b0;
    end else begin
      if (too_long) begin
        good_q <= '0;
        ld_q   <= 1'b0;
      end else if (cext_i && done_i) begin
        if (good_q < CNT_V) good_q <= good_q + 1'b1;
        if (good_q >= CNT_M1) ld_q <= 1'b1;
      end

      if (!cext_i || done_i) run_q <= '0;
      else if (run_q < WIN_V) run_q <= run_q + 1'b1;
    end
  end

  AST_LD_RISE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ld_q) |-> $past(done_i && cext_i)); // R8
  AST_LONG_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cext_i && run_q >= WIN_V) |=> !ld_q); // R9

endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
  parameter int RST_HOLD   = 2,
  parameter int LOCK_WIN   = 4,
  parameter int LOCK_COUNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_div,
  input  logic fb_div,
  output logic corr_up_n,
  output logic corr_dn_n,
  output logic pulse_nand,
  output logic lock_det
);

  logic [pfd_pkg::NUM_CH-1:0] raw;
  logic [pfd_pkg::NUM_CH-1:0] rise;
  logic up, dn, done;

  assign raw[pfd_pkg::CH_REF] = ref_div;
  assign raw[pfd_pkg::CH_FB]  = fb_div;

  generate
    for (genvar ch = 0; ch < pfd_pkg::NUM_CH; ch++) begin : g_edge
      pfd_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (raw[ch]),
        .rise_o (rise[ch])
      );
    end
  endgenerate

  pfd_core #(.RST_HOLD(RST_HOLD)) u_core (
    .clk        (clk),
    .rst        (rst),
    .rise_ref_i (rise[pfd_pkg::CH_REF]),
    .rise_fb_i  (rise[pfd_pkg::CH_FB]),
    .up_o       (up),
    .dn_o       (dn),
    .done_o     (done)
  );

  assign corr_up_n  = ~up;
  assign corr_dn_n  = ~dn;
  assign pulse_nand = ~(corr_up_n & corr_dn_n);

  pfd_lock #(.LOCK_WIN(LOCK_WIN), .LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .cext_i (pulse_nand),
    .done_i (done),
    .ld_o   (lock_det)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (corr_up_n && corr_dn_n && !lock_det)); // R1

endmodule

// File: tb/pfd_lockdet_tb.sv
module pfd_lockdet_tb;

  localparam int H   = 2;
  localparam int WIN = 4;
  localparam int LC  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_div = 1'b0;
  logic fb_div = 1'b0;
  logic corr_up_n, corr_dn_n, pulse_nand, lock_det;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pfd_lockdet #(.RST_HOLD(H), .LOCK_WIN(WIN), .LOCK_COUNT(LC)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .ref_div    (ref_div),
    .fb_div     (fb_div),
    .corr_up_n  (corr_up_n),
    .corr_dn_n  (corr_dn_n),
    .pulse_nand (pulse_nand),
    .lock_det   (lock_det)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int  m_up = 0, m_dn = 0, m_hold = 0, m_run = 0, m_good = 0, m_ld = 0;
  int  m_pc = 0, m_pp = 0;

  always @(posedge clk) begin
    int rc, rp, act, fin;
    if (rst) begin
      m_up = 0; m_dn = 0; m_hold = 0; m_run = 0; m_good = 0; m_ld = 0;
      m_pc = 0; m_pp = 0;
    end else begin
      rc = (ref_div && !m_pc) ? 1 : 0;
      rp = (fb_div && !m_pp) ? 1 : 0;
      m_pc = ref_div; m_pp = fb_div;
      act = (m_up || m_dn) ? 1 : 0;
      fin = (m_up && m_dn && m_hold == H - 1) ? 1 : 0;
      if (act && m_run >= WIN) begin
        m_good = 0; m_ld = 0;
      end else if (act && fin) begin
        if (m_good < LC) m_good++;
        if (m_good >= LC) m_ld = 1;
      end
      if (!act || fin) m_run = 0;
      else if (m_run < WIN) m_run++;
      if (m_up && m_dn) begin
        if (fin) begin m_up = 0; m_dn = 0; m_hold = 0; end
        else m_hold++;
      end else begin
        m_up = m_up | rc;
        m_dn = m_dn | rp;
      end
    end
  end

  // Pulse-width monitor and per-cycle comparison, away from the rising edge
  int run_up = 0, run_dn = 0, last_up = 0, last_dn = 0, cnt_up = 0, cnt_dn = 0;

  always @(negedge clk) begin
    chk(corr_up_n == !m_up, "R2 corr_up_n model", int'(corr_up_n), int'(!m_up));
    chk(corr_dn_n == !m_dn, "R3 corr_dn_n model", int'(corr_dn_n), int'(!m_dn));
    chk(pulse_nand == !(corr_up_n && corr_dn_n), "R6 pulse_nand",
        int'(pulse_nand), int'(!(corr_up_n && corr_dn_n)));
    chk(lock_det == m_ld[0], "R8 lock_det model", int'(lock_det), m_ld);
    if (!corr_up_n) run_up++;
    else if (run_up > 0) begin last_up = run_up; cnt_up++; run_up = 0; end
    if (!corr_dn_n) run_dn++;
    else if (run_dn > 0) begin last_dn = run_dn; cnt_dn++; run_dn = 0; end
  end

  // lead > 0: reference first; lead < 0: feedback first; 0: together
  task automatic pair(input int lead);
    int k;
    k = (lead < 0) ? -lead : lead;
    @(negedge clk);
    if (lead >= 0) ref_div = 1'b1;
    if (lead <= 0) fb_div = 1'b1;
    repeat (k) @(negedge clk);
    ref_div = 1'b1;
    fb_div = 1'b1;
    repeat (k + H + 3) @(negedge clk);
    ref_div = 1'b0;
    fb_div = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int pu, pd;
    repeat (4) @(negedge clk);
    chk(corr_up_n && corr_dn_n && !pulse_nand && !lock_det, "R1 reset state",
        int'({corr_up_n, corr_dn_n, pulse_nand, lock_det}), 4'b1100);
    rst = 1'b0;
    @(negedge clk);
    chk(corr_up_n && corr_dn_n && !lock_det, "R1 after release",
        int'({corr_up_n, corr_dn_n, lock_det}), 3'b110);

    // Equal phase; inputs held high for several clocks (R10)
    pu = cnt_up;
    pair(0);
    chk(last_up == H, "R5 equal up width", last_up, H);
    chk(last_dn == H, "R4 equal dn width", last_dn, H);
    chk(cnt_up == pu + 1, "R10 one pulse per edge", cnt_up - pu, 1);

    // Reference leads by 3
    pair(3);
    chk(last_up == 3 + H, "R2 lead up width", last_up, 3 + H);
    chk(last_dn == H, "R2 lead dn width", last_dn, H);

    // Feedback leads by 3
    pair(-3);
    chk(last_dn == 3 + H, "R3 lag dn width", last_dn, 3 + H);
    chk(last_up == H, "R3 lag up width", last_up, H);

    // Lock acquisition: bursts of 1+H clocks each
    repeat (LC - 1) pair(1);
    chk(lock_det == 1'b0, "R8 not yet locked", int'(lock_det), 0);
    pair(1);
    chk(lock_det == 1'b1, "R8 locked", int'(lock_det), 1);
    pair(-2);
    chk(lock_det == 1'b1, "R8 burst at limit keeps lock", int'(lock_det), 1);
    pair(3);
    chk(lock_det == 1'b0, "R9 long burst drops lock", int'(lock_det), 0);

    // Edge inside the hold window is ignored
    pu = cnt_up;
    @(negedge clk); ref_div = 1'b1; fb_div = 1'b1;
    @(negedge clk); ref_div = 1'b0;
    @(negedge clk); ref_div = 1'b1;
    repeat (6) @(negedge clk);
    ref_div = 1'b0; fb_div = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnt_up == pu + 1, "R7 hold edge no new pulse", cnt_up - pu, 1);
    chk(last_up == H, "R7 hold edge width", last_up, H);

    // Second reference edge while corr_up_n already low
    pu = cnt_up; pd = cnt_dn;
    @(negedge clk); ref_div = 1'b1;
    @(negedge clk); ref_div = 1'b0;
    @(negedge clk); ref_div = 1'b1;
    repeat (2) @(negedge clk);
    fb_div = 1'b1;
    repeat (H + 4) @(negedge clk);
    ref_div = 1'b0; fb_div = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnt_up == pu + 1, "R7 repeat edge one pulse", cnt_up - pu, 1);
    chk(last_up == 4 + H, "R7 repeat edge width", last_up, 4 + H);
    chk(cnt_dn == pd + 1 && last_dn == H, "R3 dn after repeat", last_dn, H);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule